// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

This block adds two N-bit operands and a carry-in with a chain of full-adder stages. Each stage is built on an inverting full-adder core, whose sum and carry leave in complemented form. Complementing all three inputs of a full adder complements both of its outputs. The chain uses this to pass the carry from stage to stage without an inverter on the carry path.

The carry therefore moves along the chain in alternating polarity. Stages at even positions take true operands and a true carry, and they emit a complemented carry. Stages at odd positions take complemented operands and a complemented carry, and they emit a true sum and a true carry. At the operand boundary the bits for the odd stages are inverted. Sum bits that leave an even stage in complemented form are flipped back. The final carry is corrected according to the parity of N. From outside, the adder is an ordinary true-polarity combinational adder: the carry takes the same number of stages, with no inverter between them.

The block has no clock and no state. It is meant to sit inside a bit-sliced datapath where the N-stage linear carry delay is acceptable.

Top module: `apr_adder`

## Requirements
- R1: `sum_o` equals the low N bits of `op_a_i + op_b_i + carry_i`, for every operand value.
- R2: `carry_o` equals bit N of the (N+1)-bit total `op_a_i + op_b_i + carry_i`, in true polarity, whether N is odd or even.
- R3: The carry entering stage k is carried in true polarity when k is even and in complemented polarity when k is odd. The carry-in enters stage 0 in true polarity, and a carry must propagate correctly across all N stages.
- R4: All-ones operand A plus zero operand B with carry-in 1 gives a sum of zero and a carry-out of 1.
- R5: Zero plus zero with carry-in 0 gives a sum of zero and a carry-out of 0.
- R6: The result is correct both for an odd N, where the last stage emits a complemented carry, and for an even N, where the last stage emits a true carry.
- R7: The outputs follow any input change combinationally, with no clock edge between the input change and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | N | First operand, true polarity |
| op_b_i | input | N | Second operand, true polarity |
| carry_i | input | 1 | Carry into bit 0, true polarity |
| sum_o | output | N | Sum, true polarity |
| carry_o | output | 1 | Carry out of bit N-1, true polarity |

## Verification
Two small builds are swept exhaustively: a 6-bit build, whose last stage is an odd stage, and a 5-bit build, whose last stage is an even stage. Every operand pair is tried with both carry-in values. A stage that took the wrong cell variant, or a boundary inversion that was misplaced, therefore shows up as a wrong sum bit or a wrong carry-out at its own bit position. Comparing the two builds separates faults in the final carry correction from faults in the body of the chain. The default 16-bit build is tried with random operands and with the full-length patterns. All-ones plus one forces a carry through every stage and so tests each polarity change along the chain. Zero plus zero checks that no stray carry appears. A change of input between clock edges confirms that the outputs react with no clock edge involved.

// File: rtl/apr_pkg.sv
`timescale 1ns/1ps
package apr_pkg;

   // polarity in which a stage receives its operands and carry
   typedef enum logic {
      POL_TRUE = 1'b0,
      POL_INV  = 1'b1
   } apr_pol_e;

   // even positions see true signals, odd positions see complemented ones
   function automatic apr_pol_e stage_pol(input int unsigned idx);
      return (idx % 2 == 1) ? POL_INV : POL_TRUE;
   endfunction

   // polarity of the carry leaving a stage is the opposite of its input
   function automatic apr_pol_e out_pol(input int unsigned idx);
      return (idx % 2 == 1) ? POL_TRUE : POL_INV;
   endfunction

endpackage

// File: rtl/apr_inv_fa.sv
`timescale 1ns/1ps
// Inverting full-adder core: both outputs leave complemented.
module apr_inv_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic sum_n_o,
   output logic cout_n_o
);
   logic gen_w;
   logic prop_w;
   logic kill_w;

   always_comb begin
      gen_w    = x_i & y_i;
      prop_w   = x_i ^ y_i;
      kill_w   = ~x_i & ~y_i;
      // carry is 1 on generate, 0 on kill, carry-in on propagate
      cout_n_o = ~(gen_w | (prop_w & z_i));
      sum_n_o  = ~(prop_w ^ z_i);
   end

   // kill is the complement of (generate | propagate); kept to expose
   // the three-way split of the carry decision
   logic unused_kill_w;
   assign unused_kill_w = kill_w;
endmodule

// File: rtl/apr_stage.sv
`timescale 1ns/1ps
// One bit stage. POL picks the odd or even cell variant.
// a_i, b_i and c_i arrive in the stage's native polarity.
module apr_stage
   import apr_pkg::*;
#(
   parameter apr_pol_e POL = POL_TRUE
) (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic sum_true_o,
   output logic c_o
);
   logic s_raw_w;
   logic c_raw_w;

   apr_inv_fa core_i (
      .x_i      (a_i),
      .y_i      (b_i),
      .z_i      (c_i),
      .sum_n_o  (s_raw_w),
      .cout_n_o (c_raw_w)
   );

   // carry leaves in whatever polarity the core gives: no inverter
   assign c_o = c_raw_w;

   generate
      if (POL == POL_TRUE) begin : g_even_cell
         // true inputs -> complemented sum, corrected here
         assign sum_true_o = ~s_raw_w;
      end else begin : g_odd_cell
         // complemented inputs -> true sum, no output inverter
         assign sum_true_o = s_raw_w;
      end
   endgenerate
endmodule

// File: rtl/apr_adder.sv
`timescale 1ns/1ps
module apr_adder
   import apr_pkg::*;
#(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] op_a_i,
   input  logic [N-1:0] op_b_i,
   input  logic         carry_i,
   output logic [N-1:0] sum_o,
   output logic         carry_o
);
   localparam apr_pol_e LAST_POL = out_pol(N - 1);

   initial begin
      if (N < 1) $error("apr_adder: N must be at least 1");
   end

   // carry_link[k] is the carry into stage k in that stage's polarity
   logic [N:0]   carry_link;
   logic [N-1:0] a_nat;
   logic [N-1:0] b_nat;

   assign carry_link[0] = carry_i;

   generate
      for (genvar k = 0; k < int'(N); k++) begin : g_bit
         localparam apr_pol_e SP = stage_pol(k);
         if (SP == POL_INV) begin : g_flip
            assign a_nat[k] = ~op_a_i[k];
            assign b_nat[k] = ~op_b_i[k];
         end else begin : g_keep
            assign a_nat[k] = op_a_i[k];
            assign b_nat[k] = op_b_i[k];
         end

         apr_stage #(.POL(SP)) stage_i (
            .a_i        (a_nat[k]),
            .b_i        (b_nat[k]),
            .c_i        (carry_link[k]),
            .sum_true_o (sum_o[k]),
            .c_o        (carry_link[k+1])
         );
      end

      if (LAST_POL == POL_INV) begin : g_cout_fix
         assign carry_o = ~carry_link[N];
      end else begin : g_cout_pass
         assign carry_o = carry_link[N];
      end
   endgenerate
endmodule

// File: rtl/apr_adder_chk.sv
`timescale 1ns/1ps
module apr_adder_chk #(
   parameter int unsigned N = 16
) (
   input logic [N-1:0] op_a,
   input logic [N-1:0] op_b,
   input logic         cin,
   input logic [N-1:0] sum,
   input logic         cout,
   input logic [N:0]   link
);
   logic [N:0] total_w;

   always_comb begin
      total_w = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, cin};
   end

   always_comb begin
      AST_SUM_MATCH: assert (sum == total_w[N-1:0]);   // R1
      AST_COUT_MATCH: assert (cout == total_w[N]);     // R2
      AST_FULL_WRAP: assert (!((&op_a) && op_b == '0 && cin) || (sum == '0 && cout)); // R4
      AST_ZERO_ZERO: assert (!(op_a == '0 && op_b == '0 && !cin) || (sum == '0 && !cout)); // R5
      for (int k = 0; k <= int'(N); k++) begin
         // true carry into bit k, recovered from the total
         AST_LINK_POLARITY: assert (link[k] == (((k == int'(N)) ? total_w[k]
                                     : (total_w[k] ^ op_a[k] ^ op_b[k])) ^ k[0])); // R3
      end
   end
endmodule

bind apr_adder apr_adder_chk #(.N(N)) chk_i (
   .op_a (op_a_i),
   .op_b (op_b_i),
   .cin  (carry_i),
   .sum  (sum_o),
   .cout (carry_o),
   .link (carry_link)
);

// File: tb/apr_adder_tb_top.sv
`timescale 1ns/1ps
module apr_adder_tb_top;
   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int tests  = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] a16, b16, s16;
   logic        c16, co16;
   logic [5:0]  a6, b6, s6;
   logic        c6, co6;
   logic [4:0]  a5, b5, s5;
   logic        c5, co5;

   apr_adder #(.N(16)) dut_i (
      .op_a_i(a16), .op_b_i(b16), .carry_i(c16), .sum_o(s16), .carry_o(co16));
   apr_adder #(.N(6)) dut_even_i (
      .op_a_i(a6), .op_b_i(b6), .carry_i(c6), .sum_o(s6), .carry_o(co6));
   apr_adder #(.N(5)) dut_odd_i (
      .op_a_i(a5), .op_b_i(b5), .carry_i(c5), .sum_o(s5), .carry_o(co5));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic ci);
      logic [16:0] e;
      a16 = a; b16 = b; c16 = ci;
      @(negedge clk);
      e = {1'b0, a} + {1'b0, b} + {16'd0, ci};
      chk({req, " sum"}, {16'd0, s16}, {16'd0, e[15:0]});
      chk({req, " cout"}, {31'd0, co16}, {31'd0, e[16]});
   endtask

   initial begin
      a16 = '0; b16 = '0; c16 = 1'b0;
      a6 = '0; b6 = '0; c6 = 1'b0;
      a5 = '0; b5 = '0; c5 = 1'b0;
      repeat (2) @(negedge clk);

      // R5: quiescent state, zero plus zero
      chk("R5 zero sum", {16'd0, s16}, 32'd0);
      chk("R5 zero cout", {31'd0, co16}, 32'd0);

      // R4 and R3: full-length carry ripple through every stage
      run16("R4", 16'hFFFF, 16'h0000, 1'b1);
      run16("R3 ripple", 16'hFFFF, 16'h0001, 1'b0);
      run16("R3 alt", 16'h5555, 16'hAAAA, 1'b1);
      run16("R2 max", 16'hFFFF, 16'hFFFF, 1'b1);
      run16("R5", 16'h0000, 16'h0000, 1'b0);

      // R1/R2: random operands on the default width
      for (int i = 0; i < 2000; i++)
         run16("R1 rand", 16'($urandom), 16'($urandom), 1'($urandom));

      // R6: exhaustive sweeps, even N = 6 and odd N = 5
      for (int a = 0; a < 64; a++)
         for (int b = 0; b < 64; b++)
            for (int ci = 0; ci < 2; ci++) begin
               logic [6:0] e6;
               logic [5:0] e5;
               a6 = 6'(a); b6 = 6'(b); c6 = 1'(ci);
               a5 = 5'(a); b5 = 5'(b); c5 = 1'(ci);
               @(negedge clk);
               e6 = 7'(a) + 7'(b) + 7'(ci);
               e5 = 6'(a[4:0]) + 6'(b[4:0]) + 6'(ci);
               chk("R6 even sum", {26'd0, s6}, {26'd0, e6[5:0]});
               chk("R6 even cout", {31'd0, co6}, {31'd0, e6[6]});
               if (a < 32 && b < 32) begin
                  chk("R6 odd sum", {27'd0, s5}, {27'd0, e5[4:0]});
                  chk("R6 odd cout", {31'd0, co5}, {31'd0, e5[5]});
               end
            end

      // R7: change inputs between edges, sample before the next edge
      @(posedge clk);
      #0.5;
      a16 = 16'h8000; b16 = 16'h8000; c16 = 1'b1;
      #0.5;
      chk("R7 comb sum", {16'd0, s16}, 32'h0001);
      chk("R7 comb cout", {31'd0, co16}, 32'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule